// File: doc/BRIEF.md
# Root Contention Resolver

This block sits on one port of a serial-bus node and settles the tie that arises when the node and its direct neighbour both try to become the parent of the other at the end of tree identification. It drives a three-valued outgoing line code (idle, request, acknowledge) and reads the same three codes from the neighbour. It uses a pseudo-random coin to choose between a short and a long back-off window. When the window opens, the node does one of two things, depending on what the neighbour has sent meanwhile:

- It claims the root role by acknowledging the neighbour.
- It offers to be the child by sending a request of its own.

A contention round begins with a single-cycle `start` pulse. Waits are measured in ticks that an external strobe supplies, normally one every 10 ns. The coin comes from a free-running 16-bit LFSR. Its bias is set by a threshold input. The root and child outcomes are held until a synchronous bus reset. Repeated contention is counted, and the block gives up with a sticky error flag once the count passes a configurable limit.

Top module: `rc_resolver`

## Requirements
- R1: After `rst_n` low, and in the cycle after `busReset` is high, `isRoot`, `isChild`, `retry`, `retryErr` and all three line outputs are low. The retry count is cleared. `busReset` takes priority over every other input.
- R2: A `start` pulse while the block is off and has no error makes `txIdle` high one cycle later. A `start` at any other time is ignored.
- R3: The coin is drawn from a 16-bit LFSR that is never zero. The fast window is chosen when the LFSR value is less than or equal to `fastThr`, so `fastThr`=0 always gives slow and `fastThr`=16'hFFFF always gives fast.
- R4: In the peer-requested wait, the block acts in the cycle after the tick count reaches the window minimum: it drives `txAck` and raises `isRoot`. The window minimum is FAST_MIN=76 ticks for fast and SLOW_MIN=159 for slow. With ticks every cycle, `isRoot` appears FAST_MIN+2 clocks after the `start` edge, which is before the window maximum.
- R5: A peer idle seen during the peer-requested wait moves the block to the peer-idle wait without restarting the timer. A later peer request moves it back to the peer-requested wait.
- R6: In the peer-idle wait, when the window minimum is reached the block drives `txReq`, clears its timer and waits for a reply. It does not become root.
- R7: While waiting for a reply, a peer acknowledge makes `isChild` high. A peer request instead gives a one-cycle `retry` pulse together with `txIdle`, followed by a fresh coin toss.
- R8: A peer idle seen in the first contention cycle, before the coin, sends the block to the peer-idle wait right after the toss. A peer request in that pre-coin idle state returns it to plain contention, which then leads to the peer-requested wait.
- R9: The wait timer advances only on cycles with `tickEn` high while waiting. It saturates at TMR_SAT=168 and is cleared on every coin toss and every line change the block makes.
- R10: At most one line output is high at a time. `isRoot` and `isChild` are never both high, and each stays high until `busReset`.
- R11: Once the contention count has reached RETRY_LIMIT=3, a further peer request in reply to the block's own request raises `retryErr`. The block then drives no line and ignores `start` until `busReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Synchronous clear of outcome, error and retry count |
| start | input | 1 | Begin a contention round |
| tickEn | input | 1 | Timer tick strobe (one per 10 ns) |
| fastThr | input | 16 | Coin threshold; fast when LFSR <= fastThr |
| peerIdle | input | 1 | Neighbour drives idle |
| peerReq | input | 1 | Neighbour drives request |
| peerAck | input | 1 | Neighbour drives acknowledge |
| txIdle | output | 1 | Block drives idle |
| txReq | output | 1 | Block drives request |
| txAck | output | 1 | Block drives acknowledge |
| isRoot | output | 1 | Block won the root role |
| isChild | output | 1 | Block became the child |
| retry | output | 1 | One-cycle pulse on repeated contention |
| retryErr | output | 1 | Contention limit exceeded |

## Verification
The assertions check the following on every cycle:

- The line code never has more than one output high.
- Root and child are exclusive, and each is held until a bus reset.
- A bus reset clears the outcome in the cycle after it.
- A child outcome only follows a peer acknowledge.
- A retry pulse always comes with idle on the line.
- An error leaves the line silent.
- The timer never passes its saturation value.

Other behaviour only the bench scenarios can show, because the bench model predicts each line change to the exact cycle:

- the exact cycle on which each window closes, for fast and slow coins;
- the effect of gated ticks;
- the moves between the wait variants, and the pre-coin detour;
- the number of rounds before the error.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_CONT,
    ST_CONT_PI,
    ST_WAIT_REQ,
    ST_WAIT_IDLE,
    ST_SENT,
    ST_ROOT,
    ST_CHILD
  } rcState_e;

  typedef enum logic [1:0] {
    LN_NONE,
    LN_IDLE,
    LN_REQ,
    LN_ACK
  } lineCode_e;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic toss;
    logic retryInc;
    logic retryClr;
  } ctrlStb_t;

endpackage

// File: rtl/rcr_dpath.sv
module rcr_dpath
  import rcr_pkg::*;
#(
  parameter int LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int FAST_MIN    = 76,
  parameter int SLOW_MIN    = 159,
  parameter int TMR_SAT     = 168,
  parameter int RETRY_LIMIT = 3,
  localparam int TMR_W      = $clog2(TMR_SAT + 1),
  localparam int CNT_W      = $clog2(RETRY_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStb_t          stb,
  input  logic              tickEn,
  input  logic [LFSR_W-1:0] fastThr,
  output logic              atMin,
  output logic              retryOver,
  output logic [TMR_W-1:0]  timerVal
);

  localparam logic [TMR_W-1:0] FAST_MIN_V = TMR_W'(FAST_MIN);
  localparam logic [TMR_W-1:0] SLOW_MIN_V = TMR_W'(SLOW_MIN);
  localparam logic [TMR_W-1:0] SAT_V      = TMR_W'(TMR_SAT);
  localparam logic [CNT_W-1:0] LIMIT_V    = CNT_W'(RETRY_LIMIT);

  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrShift;
  logic              slowSel;
  logic [CNT_W-1:0]  roundCnt;
  logic [TMR_W-1:0]  winMin;

  // free-running Galois LFSR, never reaches zero from a nonzero seed
  assign lfsrShift = {1'b0, lfsrQ[LFSR_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsrQ <= LFSR_SEED;
    else if (lfsrQ[0]) lfsrQ <= lfsrShift ^ LFSR_TAPS;
    else lfsrQ <= lfsrShift;
  end

  // coin: fast when the LFSR value is at or below the threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slowSel <= 1'b0;
    else if (stb.toss) slowSel <= !(lfsrQ <= fastThr);
  end

  // wait timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timerVal <= '0;
    else if (stb.timerClr) timerVal <= '0;
    else if (stb.timerRun && tickEn && (timerVal < SAT_V)) timerVal <= timerVal + 1'b1;
  end

  assign winMin = slowSel ? SLOW_MIN_V : FAST_MIN_V;
  assign atMin  = (timerVal >= winMin);

  // contention round counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) roundCnt <= '0;
    else if (stb.retryClr) roundCnt <= '0;
    else if (stb.retryInc && (roundCnt < LIMIT_V)) roundCnt <= roundCnt + 1'b1;
  end

  assign retryOver = (roundCnt >= LIMIT_V);

endmodule

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busReset,
  input  logic      start,
  input  logic      peerIdle,
  input  logic      peerReq,
  input  logic      peerAck,
  input  logic      atMin,
  input  logic      retryOver,
  output ctrlStb_t  stb,
  output rcState_e  state,
  output lineCode_e line,
  output logic      retryPulse,
  output logic      errFlag
);

  rcState_e  nxtState;
  lineCode_e nxtLine;
  logic      nxtErr;
  logic      nxtRetry;

  always_comb begin
    nxtState     = state;
    nxtLine      = line;
    nxtErr       = errFlag;
    nxtRetry     = 1'b0;
    stb          = '0;
    stb.timerRun = (state == ST_WAIT_REQ) || (state == ST_WAIT_IDLE);
    if (busReset) begin
      nxtState     = ST_OFF;
      nxtLine      = LN_NONE;
      nxtErr       = 1'b0;
      stb.retryClr = 1'b1;
      stb.timerClr = 1'b1;
    end else begin
      case (state)
        ST_OFF: begin
          if (start && !errFlag) begin
            nxtState     = ST_CONT;
            nxtLine      = LN_IDLE;
            stb.timerClr = 1'b1;
          end
        end
        ST_CONT: begin
          if (peerIdle) begin
            nxtState = ST_CONT_PI;
          end else begin
            nxtState     = ST_WAIT_REQ;
            stb.toss     = 1'b1;
            stb.timerClr = 1'b1;
          end
        end
        ST_CONT_PI: begin
          if (peerReq) begin
            nxtState = ST_CONT;
          end else begin
            nxtState     = ST_WAIT_IDLE;
            stb.toss     = 1'b1;
            stb.timerClr = 1'b1;
          end
        end
        ST_WAIT_REQ: begin
          if (atMin) begin
            nxtState     = ST_ROOT;
            nxtLine      = LN_ACK;
            stb.timerClr = 1'b1;
          end else if (peerIdle) begin
            nxtState = ST_WAIT_IDLE;
          end
        end
        ST_WAIT_IDLE: begin
          if (atMin) begin
            nxtState     = ST_SENT;
            nxtLine      = LN_REQ;
            stb.timerClr = 1'b1;
          end else if (peerReq) begin
            nxtState = ST_WAIT_REQ;
          end
        end
        ST_SENT: begin
          if (peerAck) begin
            nxtState = ST_CHILD;
          end else if (peerReq) begin
            if (retryOver) begin
              nxtState = ST_OFF;
              nxtLine  = LN_NONE;
              nxtErr   = 1'b1;
            end else begin
              nxtState     = ST_CONT;
              nxtLine      = LN_IDLE;
              nxtRetry     = 1'b1;
              stb.retryInc = 1'b1;
              stb.timerClr = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      line       <= LN_NONE;
      errFlag    <= 1'b0;
      retryPulse <= 1'b0;
    end else begin
      state      <= nxtState;
      line       <= nxtLine;
      errFlag    <= nxtErr;
      retryPulse <= nxtRetry;
    end
  end

endmodule

// File: rtl/rc_resolver.sv
module rc_resolver
  import rcr_pkg::*;
#(
  parameter int FAST_MIN    = 76,
  parameter int FAST_MAX    = 85,
  parameter int SLOW_MIN    = 159,
  parameter int SLOW_MAX    = 167,
  parameter int TMR_SAT     = 168,
  parameter int RETRY_LIMIT = 3,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int TMR_W      = $clog2(TMR_SAT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busReset,
  input  logic        start,
  input  logic        tickEn,
  input  logic [15:0] fastThr,
  input  logic        peerIdle,
  input  logic        peerReq,
  input  logic        peerAck,
  output logic        txIdle,
  output logic        txReq,
  output logic        txAck,
  output logic        isRoot,
  output logic        isChild,
  output logic        retry,
  output logic        retryErr
);

  ctrlStb_t         stb;
  rcState_e         state;
  lineCode_e        line;
  logic             atMin;
  logic             retryOver;
  logic [TMR_W-1:0] timerVal;

  rcr_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busReset  (busReset),
    .start     (start),
    .peerIdle  (peerIdle),
    .peerReq   (peerReq),
    .peerAck   (peerAck),
    .atMin     (atMin),
    .retryOver (retryOver),
    .stb       (stb),
    .state     (state),
    .line      (line),
    .retryPulse(retry),
    .errFlag   (retryErr)
  );

  rcr_dpath #(
    .LFSR_W     (16),
    .LFSR_SEED  (LFSR_SEED),
    .LFSR_TAPS  (16'hB400),
    .FAST_MIN   (FAST_MIN),
    .SLOW_MIN   (SLOW_MIN),
    .TMR_SAT    (TMR_SAT),
    .RETRY_LIMIT(RETRY_LIMIT)
  ) uDpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .tickEn   (tickEn),
    .fastThr  (fastThr),
    .atMin    (atMin),
    .retryOver(retryOver),
    .timerVal (timerVal)
  );

  assign txIdle  = (line == LN_IDLE);
  assign txReq   = (line == LN_REQ);
  assign txAck   = (line == LN_ACK);
  assign isRoot  = (state == ST_ROOT);
  assign isChild = (state == ST_CHILD);

endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
  parameter int TMR_W   = 8,
  parameter int TMR_SAT = 168
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busReset,
  input logic             peerAck,
  input logic             txIdle,
  input logic             txReq,
  input logic             txAck,
  input logic             isRoot,
  input logic             isChild,
  input logic             retry,
  input logic             retryErr,
  input logic [TMR_W-1:0] timerVal
);

  AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({txIdle, txReq, txAck})); // R10

  AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(isRoot && isChild)); // R10

  AST_ROOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (isRoot && !busReset) |=> isRoot); // R10

  AST_CHILD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (isChild && !busReset) |=> isChild); // R10

  AST_BUSRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> (!isRoot && !isChild && !retryErr && !txIdle && !txReq && !txAck)); // R1

  AST_ROOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isRoot) |-> txAck); // R4

  AST_CHILD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isChild) |-> $past(peerAck)); // R7

  AST_RETRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> (txIdle && !isRoot && !isChild)); // R7

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    retryErr |-> !(txIdle || txReq || txAck)); // R11

  AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    timerVal <= TMR_W'(TMR_SAT)); // R9

endmodule

bind rc_resolver rcr_checker #(.TMR_W(TMR_W), .TMR_SAT(TMR_SAT)) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busReset(busReset),
  .peerAck (peerAck),
  .txIdle  (txIdle),
  .txReq   (txReq),
  .txAck   (txAck),
  .isRoot  (isRoot),
  .isChild (isChild),
  .retry   (retry),
  .retryErr(retryErr),
  .timerVal(timerVal)
);

// File: tb/tb_rc_resolver.sv
module tb_rc_resolver;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busReset = 1'b0, start = 1'b0, tickEn = 1'b1;
  logic [15:0] fastThr = 16'hFFFF;
  logic peerIdle = 1'b0, peerReq = 1'b0, peerAck = 1'b0;
  logic txIdle, txReq, txAck, isRoot, isChild, retry, retryErr;

  int errors = 0;
  int checks = 0;
  bit cmpOn = 0;
  string curTag = "R1";

  always #10 clk = ~clk;

  rc_resolver dut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .start(start),
    .tickEn(tickEn), .fastThr(fastThr), .peerIdle(peerIdle),
    .peerReq(peerReq), .peerAck(peerAck), .txIdle(txIdle), .txReq(txReq),
    .txAck(txAck), .isRoot(isRoot), .isChild(isChild), .retry(retry),
    .retryErr(retryErr)
  );

  // behavioural reference: phase 0 off,1 contend,2 contend+peer idle,
  // 3 wait(peer req),4 wait(peer idle),5 reply wait,6 root,7 child
  int mPh, mLn, mT, mRounds;
  bit mSlow, mErr, mRetry;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPh = 0; mLn = 0; mT = 0; mRounds = 0; mSlow = 0; mErr = 0; mRetry = 0;
    end else begin
      mRetry = 0;
      if (busReset) begin
        mPh = 0; mLn = 0; mT = 0; mRounds = 0; mErr = 0;
      end else if (mPh == 0) begin
        if (start && !mErr) begin mPh = 1; mLn = 1; mT = 0; end
      end else if (mPh == 1) begin
        if (peerIdle) mPh = 2;
        else begin mPh = 3; mSlow = (fastThr == 16'h0000); mT = 0; end
      end else if (mPh == 2) begin
        if (peerReq) mPh = 1;
        else begin mPh = 4; mSlow = (fastThr == 16'h0000); mT = 0; end
      end else if (mPh == 3 || mPh == 4) begin
        if (mT >= (mSlow ? 159 : 76)) begin
          mT = 0;
          if (mPh == 3) begin mPh = 6; mLn = 3; end
          else begin mPh = 5; mLn = 2; end
        end else begin
          if (mPh == 3 && peerIdle) mPh = 4;
          else if (mPh == 4 && peerReq) mPh = 3;
          if (tickEn && mT < 168) mT = mT + 1;
        end
      end else if (mPh == 5) begin
        if (peerAck) mPh = 7;
        else if (peerReq) begin
          if (mRounds >= 3) begin mPh = 0; mLn = 0; mErr = 1; end
          else begin mRounds++; mRetry = 1; mPh = 1; mLn = 1; mT = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [6:0] act, exp;
      act = {txIdle, txReq, txAck, isRoot, isChild, retry, retryErr};
      exp = {mLn == 1, mLn == 2, mLn == 3, mPh == 6, mPh == 7, mRetry, mErr};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cycle compare: actual=%b expected=%b", curTag, act, exp);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int actV, input int expV);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actV, expV);
    end
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulseBusReset();
    busReset = 1'b1; @(negedge clk); busReset = 1'b0;
  endtask

  task automatic waitRoot(output int n);
    n = 0;
    while (!isRoot && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic waitReq(output int n);
    n = 0;
    while (!txReq && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({txIdle, txReq, txAck, isRoot, isChild, retry, retryErr} == 7'b0, "R1 reset outputs",
        {txIdle, txReq, txAck, isRoot, isChild, retry, retryErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmpOn = 1;

    // R2 / R3 / R4: fast coin, no peer change, becomes root
    curTag = "R4"; fastThr = 16'hFFFF;
    pulseStart();
    chk(txIdle == 1'b1, "R2 idle after start", txIdle, 1);
    waitRoot(n);
    chk(n == 78, "R4 fast root timing", n, 78);
    chk(txAck == 1'b1, "R4 ack driven", txAck, 1);

    // R10 hold, R2 start ignored
    curTag = "R10";
    repeat (40) @(negedge clk);
    pulseStart();
    chk(isRoot && txAck && !txIdle, "R2 start ignored while root", isRoot, 1);
    curTag = "R1";
    pulseBusReset();
    chk(!isRoot && !txAck && !txIdle, "R1 busReset clears root", isRoot, 0);

    // R3 slow coin, R5 peer idle during wait, R6 request, R7 child
    curTag = "R6"; fastThr = 16'h0000;
    pulseStart();
    repeat (10) @(negedge clk);
    peerIdle = 1'b1; @(negedge clk); peerIdle = 1'b0;
    waitReq(n);
    chk(n == 150, "R3 slow window timing", n, 150);
    chk(txReq && !isRoot, "R6 request not root", isRoot, 0);
    curTag = "R7";
    repeat (5) @(negedge clk);
    peerAck = 1'b1; @(negedge clk); peerAck = 1'b0;
    chk(isChild == 1'b1, "R7 ack makes child", isChild, 1);
    pulseBusReset();

    // R5 idle then request returns to peer-requested wait
    curTag = "R5"; fastThr = 16'hFFFF;
    pulseStart();
    repeat (5) @(negedge clk);
    peerIdle = 1'b1; @(negedge clk); peerIdle = 1'b0;
    repeat (5) @(negedge clk);
    peerReq = 1'b1; @(negedge clk); peerReq = 1'b0;
    waitRoot(n);
    chk(isRoot == 1'b1, "R5 back to requested wait gives root", isRoot, 1);
    pulseBusReset();

    // R8 pre-coin idle
    curTag = "R8";
    pulseStart();
    peerIdle = 1'b1; @(negedge clk); peerIdle = 1'b0;
    waitReq(n);
    chk(txReq == 1'b1 && n == 78, "R8 pre-coin idle goes to idle wait", n, 78);
    peerAck = 1'b1; @(negedge clk); peerAck = 1'b0;
    pulseBusReset();
    // R8 pre-coin idle then request
    pulseStart();
    peerIdle = 1'b1; @(negedge clk); peerIdle = 1'b0;
    peerReq = 1'b1; @(negedge clk); peerReq = 1'b0;
    waitRoot(n);
    chk(isRoot == 1'b1, "R8 request restores plain contention", isRoot, 1);
    pulseBusReset();

    // R9 gated ticks stretch the wait
    curTag = "R9";
    pulseStart();
    n = 0;
    while (!isRoot && n < 1000) begin tickEn = ~tickEn; @(negedge clk); n++; end
    tickEn = 1'b1;
    chk(n >= 152, "R9 timer counts only on ticks", n, 152);
    pulseBusReset();

    // R7 retries then R11 error
    curTag = "R11";
    pulseStart();
    for (int r = 1; r <= 4; r++) begin
      repeat (3) @(negedge clk);
      peerIdle = 1'b1; @(negedge clk); peerIdle = 1'b0;
      waitReq(n);
      peerReq = 1'b1; @(negedge clk); peerReq = 1'b0;
      if (r < 4) chk(retry && txIdle, "R7 retry pulse with idle", retry, 1);
      else chk(retryErr && !txIdle && !txReq, "R11 error after limit", retryErr, 1);
    end
    pulseStart();
    @(negedge clk);
    chk(!txIdle && retryErr, "R11 start ignored in error", txIdle, 0);
    curTag = "R1";
    pulseBusReset();
    chk(!retryErr, "R1 busReset clears error", retryErr, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule